// File: doc/BRIEF.md
# Power and Acquisition Sequencer Handshake

This controller sits between the power sequencing of an analog measurement front end and the sequencer that runs its acquisitions. An external power request moves the front end out of OFF. The front end passes through a settling phase of programmable length and then reaches READY. On that transition the controller can send a start pulse, and whether the start pulse becomes an acquisition trigger depends on the trigger-source setting. A software trigger strobe is the other way to start an acquisition. With automatic start and hardware trigger source both enabled, a full measurement needs no software action beyond the power request.

Software can request a stop or a power-down, and debug entry can also stop a running acquisition. In every case the stop is graceful: a stop level is held to the acquisition sequencer until it reports done. The stop and power-down status bits stay set while work is pending. They clear on the next cycle when there is nothing to stop or nothing to power off. A power-down first completes the stop handshake, then returns the front end to OFF, then clears its bit.

Top module: `pwr_acq_seq`

## Requirements
- R1: After reset, `pwr_state_o` is OFF (encoding OFF=0, RAMPING=1, READY=2, STOPPING=3) and every other output is 0.
- R2: A power request sampled in OFF moves the state to RAMPING at the next edge. The state stays in RAMPING for exactly `settle_len_i`+1 cycles and then becomes READY.
- R3: When auto-start is enabled, `acq_start_o` is high for exactly the first READY cycle after RAMPING. When auto-start is disabled it stays low.
- R4: `acq_trig_o` pulses together with `acq_start_o` only when the hardware trigger source is selected. With software source selected, the start pulse is ignored.
- R5: With software source selected, a trigger strobe gives a one-cycle `acq_trig_o` in the next cycle, whatever the auto-start setting. With hardware source selected, the strobe has no effect.
- R6: Hardware source with auto-start disabled raises `cfg_bad_o`, and no acquisition trigger is issued in that configuration.
- R7: `acq_busy_o` rises with `acq_trig_o` and falls in the cycle after `acq_done_i` is sampled.
- R8: A stop strobe while busy sets `stop_pend_o` in the next cycle and raises `acq_stop_o` one cycle later. Both stay high until `acq_done_i` is sampled and then fall together. The power state does not change.
- R9: A stop strobe while idle shows `stop_pend_o` for exactly one cycle, and `acq_stop_o` stays low.
- R10: Debug entry while busy raises `acq_stop_o` in the next cycle and holds it until `acq_done_i`. The power state is unchanged. Debug entry while idle has no effect.
- R11: A power-down strobe while busy sets `pdn_pend_o`, then the state becomes STOPPING with `acq_stop_o` high. After `acq_done_i` the state becomes OFF, and `pdn_pend_o` clears one cycle after that.
- R12: A power-down strobe while OFF shows `pdn_pend_o` for exactly one cycle, and the state stays OFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_req_i | input | 1 | External power-up request |
| dbg_entry_i | input | 1 | Debug-entry event, one cycle |
| cfg_we_i | input | 1 | Load the two trigger configuration bits |
| cfg_auto_i | input | 1 | Auto-start enable value to load |
| cfg_hwsrc_i | input | 1 | Hardware trigger source select value to load |
| settle_len_i | input | CNT_W | Settling length in cycles, minus one |
| stop_wr_i | input | 1 | Software stop request strobe |
| pdn_wr_i | input | 1 | Software power-down request strobe |
| swtrig_wr_i | input | 1 | Software acquisition trigger strobe |
| acq_done_i | input | 1 | Acquisition sequencer reports done or stopped |
| pwr_state_o | output | 2 | Front-end power state |
| acq_start_o | output | 1 | Start pulse on the entry to READY |
| acq_trig_o | output | 1 | Acquisition trigger pulse |
| acq_stop_o | output | 1 | Graceful stop request level |
| acq_busy_o | output | 1 | Acquisition in progress |
| stop_pend_o | output | 1 | Stop status bit |
| pdn_pend_o | output | 1 | Power-down status bit |
| cfg_bad_o | output | 1 | Unsupported trigger configuration |

## Verification
The power-up path is swept over settling lengths 0 to 5 crossed with all four combinations of auto-start and trigger source. This separates an off-by-one in the settle count from errors in trigger routing, and it shows that the unsupported combination never triggers. Stop, debug and power-down are each applied once with an acquisition running and once idle. This separates the held handshake from the one-cycle self-clear. The software strobe is applied under both trigger sources to show that it is ignored when the hardware source is selected.

// File: rtl/pah_pkg.sv
package pah_pkg;
  typedef enum logic [1:0] {
    PS_OFF   = 2'd0,
    PS_RAMP  = 2'd1,
    PS_READY = 2'd2,
    PS_STOP  = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/pah_power_fsm.sv
module pah_power_fsm
  import pah_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_req_i,
  input  logic             pdn_pend_i,
  input  logic             busy_i,
  input  logic [CNT_W-1:0] settle_len_i,
  output pwr_state_e       state_o,
  output logic             ramp_done_o
);
  pwr_state_e       state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;

  // settling finished and no power-down pending
  assign ramp_done_o = (state_q == PS_RAMP) && (cnt_q == settle_len_i) && !pdn_pend_i;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      PS_OFF:   if (pwr_req_i && !pdn_pend_i) state_n = PS_RAMP;
      PS_RAMP: begin
        if (pdn_pend_i)       state_n = PS_STOP;
        else if (ramp_done_o) state_n = PS_READY;
      end
      PS_READY: if (pdn_pend_i) state_n = PS_STOP;
      PS_STOP:  if (!busy_i)    state_n = PS_OFF;
      default:  state_n = PS_OFF;
    endcase
  end

  // counter runs only while ramping, parked at zero otherwise
  assign cnt_en = (state_q == PS_RAMP) || (cnt_q != '0);
  always_comb begin
    cnt_n = '0;
    if (state_q == PS_RAMP) cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_n;
      if (cnt_en) cnt_q <= cnt_n;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/pah_trig_route.sv
module pah_trig_route (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we_i,
  input  logic cfg_auto_i,
  input  logic cfg_hwsrc_i,
  input  logic ramp_done_i,
  input  logic swtrig_wr_i,
  input  logic acq_done_i,
  output logic start_o,
  output logic trig_o,
  output logic busy_o,
  output logic cfg_bad_o
);
  logic auto_q, hwsrc_q;
  logic start_q, start_n;
  logic trig_q, trig_n;
  logic busy_q, busy_n;

  always_comb begin
    start_n = ramp_done_i && auto_q;
    trig_n  = (start_n && hwsrc_q) || (swtrig_wr_i && !hwsrc_q);
    busy_n  = (busy_q && !acq_done_i) || trig_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_q  <= 1'b0;
      hwsrc_q <= 1'b0;
    end else if (cfg_we_i) begin
      auto_q  <= cfg_auto_i;
      hwsrc_q <= cfg_hwsrc_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      trig_q  <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      start_q <= start_n;
      trig_q  <= trig_n;
      busy_q  <= busy_n;
    end
  end

  assign start_o   = start_q;
  assign trig_o    = trig_q;
  assign busy_o    = busy_q;
  assign cfg_bad_o = hwsrc_q && !auto_q;
endmodule

// File: rtl/pah_stop_ctrl.sv
module pah_stop_ctrl
  import pah_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_wr_i,
  input  logic       pdn_wr_i,
  input  logic       dbg_entry_i,
  input  logic       busy_i,
  input  logic       acq_done_i,
  input  pwr_state_e state_i,
  output logic       stop_pend_o,
  output logic       pdn_pend_o,
  output logic       stop_o
);
  logic stop_q, stop_n;
  logic pdn_q, pdn_n;
  logic hs_q, hs_n;

  always_comb begin
    // stop bit: held while an acquisition runs, released on done or when idle
    stop_n = stop_q;
    if (stop_wr_i)                            stop_n = 1'b1;
    else if (stop_q && (!busy_i || acq_done_i)) stop_n = 1'b0;

    // power-down bit: released once the front end sits in OFF
    pdn_n = pdn_q;
    if (pdn_wr_i)                         pdn_n = 1'b1;
    else if (pdn_q && state_i == PS_OFF)  pdn_n = 1'b0;

    // handshake level to the acquisition sequencer
    hs_n = busy_i && !acq_done_i && (hs_q || stop_q || pdn_q || dbg_entry_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      pdn_q  <= 1'b0;
      hs_q   <= 1'b0;
    end else begin
      stop_q <= stop_n;
      pdn_q  <= pdn_n;
      hs_q   <= hs_n;
    end
  end

  assign stop_pend_o = stop_q;
  assign pdn_pend_o  = pdn_q;
  assign stop_o      = hs_q;
endmodule

// File: rtl/pwr_acq_seq.sv
module pwr_acq_seq
  import pah_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_req_i,
  input  logic             dbg_entry_i,
  input  logic             cfg_we_i,
  input  logic             cfg_auto_i,
  input  logic             cfg_hwsrc_i,
  input  logic [CNT_W-1:0] settle_len_i,
  input  logic             stop_wr_i,
  input  logic             pdn_wr_i,
  input  logic             swtrig_wr_i,
  input  logic             acq_done_i,
  output logic [1:0]       pwr_state_o,
  output logic             acq_start_o,
  output logic             acq_trig_o,
  output logic             acq_stop_o,
  output logic             acq_busy_o,
  output logic             stop_pend_o,
  output logic             pdn_pend_o,
  output logic             cfg_bad_o
);
  pwr_state_e state;
  logic       ramp_done;
  logic       busy;
  logic       pdn_pend;

  pah_power_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_req_i    (pwr_req_i),
    .pdn_pend_i   (pdn_pend),
    .busy_i       (busy),
    .settle_len_i (settle_len_i),
    .state_o      (state),
    .ramp_done_o  (ramp_done)
  );

  pah_trig_route u_trig (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we_i    (cfg_we_i),
    .cfg_auto_i  (cfg_auto_i),
    .cfg_hwsrc_i (cfg_hwsrc_i),
    .ramp_done_i (ramp_done),
    .swtrig_wr_i (swtrig_wr_i),
    .acq_done_i  (acq_done_i),
    .start_o     (acq_start_o),
    .trig_o      (acq_trig_o),
    .busy_o      (busy),
    .cfg_bad_o   (cfg_bad_o)
  );

  pah_stop_ctrl u_stop (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_wr_i   (stop_wr_i),
    .pdn_wr_i    (pdn_wr_i),
    .dbg_entry_i (dbg_entry_i),
    .busy_i      (busy),
    .acq_done_i  (acq_done_i),
    .state_i     (state),
    .stop_pend_o (stop_pend_o),
    .pdn_pend_o  (pdn_pend),
    .stop_o      (acq_stop_o)
  );

  assign pwr_state_o = state;
  assign acq_busy_o  = busy;
  assign pdn_pend_o  = pdn_pend;
endmodule

// File: rtl/pwr_acq_seq_chk.sv
module pwr_acq_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stop_wr_i,
  input logic       pdn_wr_i,
  input logic       acq_done_i,
  input logic [1:0] pwr_state_o,
  input logic       acq_start_o,
  input logic       acq_trig_o,
  input logic       acq_stop_o,
  input logic       acq_busy_o,
  input logic       stop_pend_o,
  input logic       pdn_pend_o,
  input logic       cfg_bad_o
);
  a_r3_start_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
    acq_start_o |-> (pwr_state_o == 2'd2) && ($past(pwr_state_o) == 2'd1));

  a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    acq_start_o |=> !acq_start_o);

  a_r6_bad_no_trig: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bad_o |=> !acq_trig_o);

  a_r7_trig_busy: assert property (@(posedge clk) disable iff (!rst_n)
    acq_trig_o |-> acq_busy_o);

  a_r8_stop_held: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_stop_o && !acq_done_i) |=> acq_stop_o);

  a_r8_stop_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    acq_stop_o |-> acq_busy_o);

  a_r9_idle_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_pend_o && !acq_busy_o && !stop_wr_i) |=> !stop_pend_o);

  a_r11_stopping_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state_o == 2'd3) |=> (pwr_state_o == 2'd3) || (pwr_state_o == 2'd0));

  a_r12_off_pdn_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pdn_pend_o && pwr_state_o == 2'd0 && !pdn_wr_i) |=> !pdn_pend_o);
endmodule

bind pwr_acq_seq pwr_acq_seq_chk u_pwr_acq_seq_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stop_wr_i   (stop_wr_i),
  .pdn_wr_i    (pdn_wr_i),
  .acq_done_i  (acq_done_i),
  .pwr_state_o (pwr_state_o),
  .acq_start_o (acq_start_o),
  .acq_trig_o  (acq_trig_o),
  .acq_stop_o  (acq_stop_o),
  .acq_busy_o  (acq_busy_o),
  .stop_pend_o (stop_pend_o),
  .pdn_pend_o  (pdn_pend_o),
  .cfg_bad_o   (cfg_bad_o)
);

// File: tb/test_pwr_acq_seq.sv
`timescale 1ns/1ps
module test_pwr_acq_seq;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pwr_req_i = 1'b0, dbg_entry_i = 1'b0, cfg_we_i = 1'b0;
  logic             cfg_auto_i = 1'b0, cfg_hwsrc_i = 1'b0;
  logic [CNT_W-1:0] settle_len_i = '0;
  logic             stop_wr_i = 1'b0, pdn_wr_i = 1'b0, swtrig_wr_i = 1'b0, acq_done_i = 1'b0;
  logic [1:0]       pwr_state_o;
  logic             acq_start_o, acq_trig_o, acq_stop_o, acq_busy_o;
  logic             stop_pend_o, pdn_pend_o, cfg_bad_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pwr_acq_seq #(.CNT_W(CNT_W)) i_pwr_acq_seq (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_cfg(input bit au, input bit hw);
    cfg_auto_i = au; cfg_hwsrc_i = hw; cfg_we_i = 1'b1;
    tick();
    cfg_we_i = 1'b0;
  endtask

  task automatic power_off();
    pdn_wr_i = 1'b1; tick(); pdn_wr_i = 1'b0;
    for (int k = 0; k < 20 && pwr_state_o != 2'd0; k++) tick();
    tick();
    chk("R11 back to OFF", pwr_state_o, 0);
    chk("R11 pdn bit clear", pdn_pend_o, 0);
  endtask

  task automatic power_up(input int len, input bit au, input bit hw);
    int n;
    settle_len_i = CNT_W'(len);
    set_cfg(au, hw);
    chk("R6 unsupported flag", cfg_bad_o, int'(hw && !au));
    pwr_req_i = 1'b1; tick(); pwr_req_i = 1'b0;
    chk("R2 ramp entry", pwr_state_o, 1);
    n = 0;
    while (pwr_state_o == 2'd1 && n < 300) begin
      if (acq_start_o) chk("R3 no start while ramping", 1, 0);
      n++; tick();
    end
    chk("R2 ramp length", n, len + 1);
    chk("R2 ready", pwr_state_o, 2);
    chk("R3 start pulse", acq_start_o, int'(au));
    chk("R4 hw trigger routing", acq_trig_o, int'(au && hw));
    chk("R7 busy with trigger", acq_busy_o, int'(au && hw));
    tick();
    chk("R3 start one cycle", acq_start_o, 0);
    if (acq_busy_o) begin
      acq_done_i = 1'b1; tick(); acq_done_i = 1'b0;
      chk("R7 busy falls after done", acq_busy_o, 0);
    end
  endtask

  task automatic sw_trigger(input int exp);
    swtrig_wr_i = 1'b1; tick(); swtrig_wr_i = 1'b0;
    chk("R5 sw trigger pulse", acq_trig_o, exp);
    chk("R7 busy after sw trigger", acq_busy_o, exp);
    tick();
    chk("R5 sw trigger one cycle", acq_trig_o, 0);
  endtask

  initial begin
    repeat (3) tick();
    chk("R1 reset state", pwr_state_o, 0);
    chk("R1 reset outputs", {acq_start_o, acq_trig_o, acq_stop_o, acq_busy_o,
                             stop_pend_o, pdn_pend_o, cfg_bad_o}, 0);
    rst_n = 1'b1;
    tick();

    // sweep settle length and trigger configuration
    for (int len = 0; len < 6; len++)
      for (int c = 0; c < 4; c++) begin
        power_up(len, c[0], c[1]);
        power_off();
      end

    // software trigger, auto on and off, software source
    power_up(2, 1'b1, 1'b0);
    sw_trigger(1);
    acq_done_i = 1'b1; tick(); acq_done_i = 1'b0;
    set_cfg(1'b0, 1'b0);
    sw_trigger(1);
    acq_done_i = 1'b1; tick(); acq_done_i = 1'b0;

    // R8: stop while busy
    sw_trigger(1);
    stop_wr_i = 1'b1; tick(); stop_wr_i = 1'b0;
    chk("R8 stop bit set", stop_pend_o, 1);
    chk("R8 stop level not yet", acq_stop_o, 0);
    tick();
    chk("R8 stop level", acq_stop_o, 1);
    repeat (4) tick();
    chk("R8 stop held", acq_stop_o, 1);
    chk("R8 stop bit held", stop_pend_o, 1);
    chk("R8 state kept", pwr_state_o, 2);
    acq_done_i = 1'b1; tick(); acq_done_i = 1'b0;
    chk("R8 stop level released", acq_stop_o, 0);
    chk("R8 stop bit released", stop_pend_o, 0);
    chk("R8 state after", pwr_state_o, 2);

    // R9: stop while idle
    stop_wr_i = 1'b1; tick(); stop_wr_i = 1'b0;
    chk("R9 idle stop bit shown", stop_pend_o, 1);
    chk("R9 idle no stop level", acq_stop_o, 0);
    tick();
    chk("R9 idle stop bit cleared", stop_pend_o, 0);
    chk("R9 idle no stop level later", acq_stop_o, 0);

    // R10: debug entry
    sw_trigger(1);
    dbg_entry_i = 1'b1; tick(); dbg_entry_i = 1'b0;
    chk("R10 debug stop level", acq_stop_o, 1);
    repeat (3) tick();
    chk("R10 debug stop held", acq_stop_o, 1);
    chk("R10 state kept", pwr_state_o, 2);
    acq_done_i = 1'b1; tick(); acq_done_i = 1'b0;
    chk("R10 debug stop released", acq_stop_o, 0);
    dbg_entry_i = 1'b1; tick(); dbg_entry_i = 1'b0;
    tick();
    chk("R10 idle debug no stop", acq_stop_o, 0);
    chk("R10 idle debug state", pwr_state_o, 2);

    // R5: strobe ignored with hardware source
    set_cfg(1'b1, 1'b1);
    sw_trigger(0);

    // R11: power-down while busy
    set_cfg(1'b0, 1'b0);
    sw_trigger(1);
    pdn_wr_i = 1'b1; tick(); pdn_wr_i = 1'b0;
    chk("R11 pdn bit set", pdn_pend_o, 1);
    chk("R11 still ready", pwr_state_o, 2);
    tick();
    chk("R11 stopping", pwr_state_o, 3);
    chk("R11 stop level", acq_stop_o, 1);
    repeat (3) tick();
    chk("R11 stopping held", pwr_state_o, 3);
    acq_done_i = 1'b1; tick(); acq_done_i = 1'b0;
    chk("R11 stop level released", acq_stop_o, 0);
    chk("R11 still stopping", pwr_state_o, 3);
    tick();
    chk("R11 off", pwr_state_o, 0);
    chk("R11 pdn bit until off", pdn_pend_o, 1);
    tick();
    chk("R11 pdn bit cleared", pdn_pend_o, 0);

    // R12: power-down while off
    pdn_wr_i = 1'b1; tick(); pdn_wr_i = 1'b0;
    chk("R12 pdn bit shown", pdn_pend_o, 1);
    tick();
    chk("R12 pdn bit cleared", pdn_pend_o, 0);
    chk("R12 state off", pwr_state_o, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule